// File: doc/BRIEF.md
# Resource Tag World-Wide-Name Extractor

This block finds a 64-bit world-wide name inside a configuration image of up to 128 bytes held in nonvolatile storage. The image is a chain of resource tags. Each tag is either a one-byte "small" header that carries its own short length, or a "large" header followed by a 16-bit little-endian length. One large resource, name 0x0D, holds a chain of keyed sub-fields. The sub-field with key 0x3C holds the eight name bytes.

A one-cycle `start` begins a scan from byte 0. The block fetches bytes through a synchronous read port: it drives an address with `rd_en`, and the byte comes back on `rd_data` on the next cycle. When the walk ends, `done` pulses for one cycle. The name, its byte offset and a found flag are then valid, and they hold until the next `start`. Offset 0 means that no name was located.

Top module: `wwn_scan`

## Requirements
- R1: After reset, `done`, `found`, `rd_en`, `wwn` and `wwn_offset` are all zero.
- R2: A tag byte with bit 7 clear is a small tag. It spans 1 + bits[2:0] bytes and its name is bits[6:3]. Name 0xF (for example 0x78 or 0x7F) ends the scan at once, whatever its length bits.
- R3: A tag byte with bit 7 set is a large tag with name bits[6:0]. It spans 3 + L bytes, where L is the next byte (low) plus 256 times the byte after it (high).
- R4: In large tag 0x0D, if the byte right after the 3-byte header is 0x3B, the tag spans exactly 6 bytes and none of its contents are parsed as sub-fields.
- R5: Otherwise the contents of tag 0x0D are parsed as sub-fields starting at header + 3. Each sub-field has a key in bits[5:0] of its first byte and a 16-bit little-endian length in the next two bytes. It spans length + 3 bytes. Parsing stops once the next sub-field would start at or past the tag's end. The walk then resumes at the tag's end.
- R6: In a sub-field with key 0x3C, the eight bytes after its header are the name. The first of them goes to `wwn[63:56]` and the last to `wwn[7:0]`. `wwn_offset` is the address of the first of them.
- R7: If no name is located, `wwn_offset`, `found` and `wwn` are zero after `done`, even when an earlier scan had found one.
- R8: No read is issued at an address of 128 or more. A walk that needs such a byte (a tag start, a length byte or a name byte) ends the scan. A name cut short this way is not reported.
- R9: `done` is a single-cycle pulse per scan. At `done`, `found` equals (`wwn_offset` != 0). A `start` that arrives while a scan is running is ignored.
- R10: `rd_en` is never high on two cycles in a row. Each byte is taken from `rd_data` on the cycle after its `rd_en`.
- R11: Tags outside 0x0D are skipped by length, even if their payload looks like a sub-field. If several key 0x3C sub-fields are found, the last one read is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to scan from byte 0 |
| rd_en | output | 1 | Read strobe to the image storage |
| rd_addr | output | 7 | Byte address of the read |
| rd_data | input | 8 | Byte returned one cycle after `rd_en` |
| done | output | 1 | One-cycle pulse when the scan ends |
| found | output | 1 | A name was located by the last scan |
| wwn | output | 64 | Name bytes, first byte in the top bits |
| wwn_offset | output | 7 | Address of the first name byte, 0 if none |

## Verification
The bench covers five corner cases.
- Lengths whose high byte is nonzero. A design that drops the high byte would land on a fake name placed right after the header.
- The 0x3B marker. A design that ignores it would walk a long bogus extent and miss the real name behind the short one.
- A name sub-field cut off at the end of the image. A design that wraps its address back to 0 would report a name of garbage bytes.
- A name that ends exactly on the last byte, which a design with an off-by-one bound would lose.
- Look-alike payloads inside other large tags, a second name sub-field, end tags with nonzero length bits, and a `start` sent mid-scan. A wrong design would report the wrong name, a false match, or a second `done`.

// File: rtl/wwn_scan_pkg.sv
package wwn_scan_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} scan_st_t;

  // what the byte in flight is for
  typedef enum logic [2:0] {
    FT_TAG, FT_LEN_LO, FT_LEN_HI, FT_FIRST,
    FT_SUB, FT_SLEN_LO, FT_SLEN_HI, FT_NAME
  } fetch_t;

  localparam logic [3:0] END_TAG_NAME = 4'hF;
  localparam logic [6:0] CFG_RES_NAME = 7'h0D;
  localparam logic [7:0] SHORT_MARK   = 8'h3B;
  localparam logic [5:0] NAME_KEY     = 6'h3C;
  localparam int         HDR_BYTES    = 3;
  localparam int         SHORT_SPAN   = 6;

  function automatic logic is_large(input logic [7:0] b);
    return b[7];
  endfunction

  function automatic logic [3:0] small_span(input logic [7:0] b);
    return 4'd1 + {1'b0, b[2:0]};
  endfunction

  function automatic logic [3:0] small_name(input logic [7:0] b);
    return b[6:3];
  endfunction

  function automatic logic [15:0] le16(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/wwn_rd_port.sv
module wwn_rd_port #(
  parameter int BUF_BYTES = 128,
  parameter int ADDR_W    = 7,
  parameter int PTR_W     = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [PTR_W-1:0]  req_ptr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              oob,
  output logic              rvalid
);
  assign oob     = req && (req_ptr >= PTR_W'(BUF_BYTES));
  assign rd_en   = req && !oob;
  assign rd_addr = req_ptr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd_en;
  end
endmodule

// File: rtl/wwn_capture.sv
module wwn_capture #(
  parameter int ADDR_W    = 7,
  parameter int WWN_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   shift,
  input  logic [7:0]             byte_in,
  input  logic [ADDR_W-1:0]      base_off,
  output logic                   last,
  output logic [8*WWN_BYTES-1:0] wwn,
  output logic [ADDR_W-1:0]      offset,
  output logic                   found
);
  localparam int WWN_W = 8 * WWN_BYTES;
  localparam int CNT_W = $clog2(WWN_BYTES);

  logic [CNT_W-1:0] cnt;
  logic [WWN_W-9:0] partial;

  assign last = shift && (cnt == CNT_W'(WWN_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; partial <= '0; wwn <= '0; offset <= '0; found <= 1'b0;
    end else if (clear) begin
      cnt <= '0; partial <= '0; wwn <= '0; offset <= '0; found <= 1'b0;
    end else if (shift) begin
      if (last) begin
        cnt    <= '0;
        wwn    <= {partial, byte_in};
        offset <= base_off;
        found  <= 1'b1;
      end else begin
        cnt     <= cnt + 1'b1;
        partial <= {partial[WWN_W-17:0], byte_in};
      end
    end
  end
endmodule

// File: rtl/wwn_walker.sv
module wwn_walker
  import wwn_scan_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PTR_W  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              oob,
  input  logic              rvalid,
  input  logic [7:0]        rbyte,
  input  logic              cap_last,
  output logic              req,
  output logic [PTR_W-1:0]  req_ptr,
  output logic              cap_clear,
  output logic              cap_shift,
  output logic [ADDR_W-1:0] cap_base,
  output logic              done,
  output logic              busy
);
  scan_st_t         st;
  fetch_t           ft;
  logic [PTR_W-1:0] ptr, tag_i, res_end, sub_j;
  logic [6:0]       res_name;
  logic [5:0]       sub_key;
  logic [7:0]       len_lo;
  logic [15:0]      sub_len;

  logic [PTR_W-1:0] small_next, large_next, sub_next_hdr, sub_next_name, sub_next;
  logic             take;

  assign small_next    = tag_i + PTR_W'(small_span(rbyte));
  assign large_next    = tag_i + PTR_W'(le16(len_lo, rbyte)) + PTR_W'(HDR_BYTES);
  assign sub_next_hdr  = sub_j + PTR_W'(le16(len_lo, rbyte)) + PTR_W'(HDR_BYTES);
  assign sub_next_name = sub_j + PTR_W'(sub_len) + PTR_W'(HDR_BYTES);
  assign sub_next      = (ft == FT_NAME) ? sub_next_name : sub_next_hdr;
  assign take          = (st == ST_WAIT) && rvalid;

  assign req       = (st == ST_ISSUE);
  assign req_ptr   = ptr;
  assign done      = (st == ST_DONE);
  assign busy      = (st != ST_IDLE);
  assign cap_clear = (st == ST_IDLE) && start;
  assign cap_shift = take && (ft == FT_NAME);
  assign cap_base  = ADDR_W'(sub_j + PTR_W'(HDR_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ft <= FT_TAG; ptr <= '0; tag_i <= '0; res_end <= '0;
      sub_j <= '0; res_name <= '0; sub_key <= '0; len_lo <= '0; sub_len <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st <= ST_ISSUE; ft <= FT_TAG; ptr <= '0; tag_i <= '0;
        end
        ST_ISSUE: st <= oob ? ST_DONE : ST_WAIT;
        ST_DONE:  st <= ST_IDLE;
        ST_WAIT: if (take) begin
          st <= ST_ISSUE;
          case (ft)
            FT_TAG: begin
              if (!is_large(rbyte)) begin
                if (small_name(rbyte) == END_TAG_NAME) st <= ST_DONE;
                else begin tag_i <= small_next; ptr <= small_next; end
              end else begin
                res_name <= rbyte[6:0]; ptr <= tag_i + PTR_W'(1); ft <= FT_LEN_LO;
              end
            end
            FT_LEN_LO: begin len_lo <= rbyte; ptr <= tag_i + PTR_W'(2); ft <= FT_LEN_HI; end
            FT_LEN_HI: begin
              if (res_name == CFG_RES_NAME) begin
                res_end <= large_next;
                sub_j   <= tag_i + PTR_W'(HDR_BYTES);
                ptr     <= tag_i + PTR_W'(HDR_BYTES);
                ft      <= FT_FIRST;
              end else begin
                tag_i <= large_next; ptr <= large_next; ft <= FT_TAG;
              end
            end
            FT_FIRST: begin
              if (rbyte == SHORT_MARK) begin
                tag_i <= tag_i + PTR_W'(SHORT_SPAN); ptr <= tag_i + PTR_W'(SHORT_SPAN);
                ft <= FT_TAG;
              end else if (sub_j < res_end) begin
                // the first byte doubles as the first sub-field key
                sub_key <= rbyte[5:0]; ptr <= sub_j + PTR_W'(1); ft <= FT_SLEN_LO;
              end else begin
                tag_i <= res_end; ptr <= res_end; ft <= FT_TAG;
              end
            end
            FT_SUB:     begin sub_key <= rbyte[5:0]; ptr <= sub_j + PTR_W'(1); ft <= FT_SLEN_LO; end
            FT_SLEN_LO: begin len_lo <= rbyte; ptr <= sub_j + PTR_W'(2); ft <= FT_SLEN_HI; end
            FT_SLEN_HI, FT_NAME: begin
              if (ft == FT_SLEN_HI) sub_len <= le16(len_lo, rbyte);
              if (ft == FT_SLEN_HI && sub_key == NAME_KEY) begin
                ptr <= sub_j + PTR_W'(HDR_BYTES); ft <= FT_NAME;
              end else if (ft == FT_NAME && !cap_last) begin
                ptr <= ptr + PTR_W'(1);
              end else begin
                sub_j <= sub_next;
                if (sub_next < res_end) begin ptr <= sub_next; ft <= FT_SUB; end
                else begin tag_i <= res_end; ptr <= res_end; ft <= FT_TAG; end
              end
            end
            default: st <= ST_DONE;
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wwn_scan.sv
module wwn_scan #(
  parameter int BUF_BYTES = 128,
  parameter int WWN_BYTES = 8,
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int WWN_W    = 8 * WWN_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              found,
  output logic [WWN_W-1:0]  wwn,
  output logic [ADDR_W-1:0] wwn_offset
);
  // room for tag start + 16-bit length + header without wrap
  localparam int PTR_W = ADDR_W + 18;

  logic              req, oob, rvalid, busy;
  logic [PTR_W-1:0]  req_ptr;
  logic              cap_clear, cap_shift, cap_last;
  logic [ADDR_W-1:0] cap_base;

  wwn_rd_port #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .req(req), .req_ptr(req_ptr),
    .rd_en(rd_en), .rd_addr(rd_addr), .oob(oob), .rvalid(rvalid)
  );

  wwn_walker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .oob(oob), .rvalid(rvalid),
    .rbyte(rd_data), .cap_last(cap_last), .req(req), .req_ptr(req_ptr),
    .cap_clear(cap_clear), .cap_shift(cap_shift), .cap_base(cap_base),
    .done(done), .busy(busy)
  );

  wwn_capture #(.ADDR_W(ADDR_W), .WWN_BYTES(WWN_BYTES)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear(cap_clear), .shift(cap_shift),
    .byte_in(rd_data), .base_off(cap_base), .last(cap_last),
    .wwn(wwn), .offset(wwn_offset), .found(found)
  );
endmodule

// File: rtl/wwn_scan_chk.sv
module wwn_scan_chk #(
  parameter int BUF_BYTES = 128,
  parameter int ADDR_W    = 7,
  parameter int PTR_W     = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [PTR_W-1:0]  req_ptr,
  input logic              busy,
  input logic              done,
  input logic              found,
  input logic [ADDR_W-1:0] wwn_offset
);
  p_rd_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  p_rd_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (req_ptr < PTR_W'(BUF_BYTES)) && (rd_addr == req_ptr[ADDR_W-1:0]));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_found_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (found == (wwn_offset != '0)));

  p_offset_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (wwn_offset >= ADDR_W'(6)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en);
endmodule

bind wwn_scan wwn_scan_chk #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .req_ptr(req_ptr),
  .busy(busy), .done(done), .found(found), .wwn_offset(wwn_offset)
);

// File: tb/wwn_scan_tb.sv
module wwn_scan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // first byte of the image is the top byte of each entry
  localparam logic [255:0] IMG [NVEC] = '{
    256'h820100AA_8D0B003C_08001122_33445566_77887800_00000000_00000000_00000000,
    256'h13000000_0A00008D_1000C102_00EEEEFC_0800DEAD_BEEF0123_45677800_00000000,
    256'h8D20003B_00008D0B_003C0800_A1A2A3A4_A5A6A7A8_78000000_00000000_00000000,
    256'h8D050001_0200ABCD_78000000_00000000_00000000_00000000_00000000_00000000,
    256'h850B003C_08000102_03040506_07087800_00000000_00000000_00000000_00000000,
    256'h788D0B00_3C080011_22334455_66778800_00000000_00000000_00000000_00000000,
    256'h00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000,
    256'h8D16003C_08000102_03040506_07083C08_00F1F2F3_F4F5F6F7_F8780000_00000000
  };
  localparam int EXP_OFF [NVEC] = '{10, 18, 12, 0, 0, 0, 0, 17};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_en;
  logic [6:0]  rd_addr;
  logic [7:0]  rd_data = 8'h00;
  logic        done, found;
  logic [63:0] wwn;
  logic [6:0]  wwn_offset;

  logic [7:0] mem [128];
  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int gap_err = 0;
  logic rd_prev = 1'b0;
  logic        r_found;
  logic [6:0]  r_off;
  logic [63:0] r_wwn;

  always #(CLK_PERIOD/2) clk = ~clk;

  wwn_scan u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .found(found), .wwn(wwn), .wwn_offset(wwn_offset)
  );

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (rd_en && rd_prev) gap_err++;
    rd_prev = rd_en;
  end

  function automatic string vec_tag(input int v);
    case (v)
      0: return "R3/R6 basic";
      1: return "R2/R5 small tags and keyed sub-fields";
      2: return "R4 short marker";
      3: return "R7 no key";
      4: return "R11 foreign large tag";
      5: return "R2 end tag first";
      6: return "R8 walk to buffer end";
      default: return "R11 last key wins";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_img(input logic [255:0] img);
    for (int k = 0; k < 128; k++) mem[k] = (k < 32) ? img[255 - 8*k -: 8] : 8'h00;
  endtask

  function automatic logic [63:0] exp_wwn(input int off);
    logic [63:0] w = '0;
    if (off != 0) for (int k = 0; k < 8; k++) w = {w[55:0], mem[off + k]};
    return w;
  endfunction

  task automatic run_scan(input string req);
    int n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done, {req, " done seen"}, 64'(done), 64'd1);
    r_found = found; r_off = wwn_offset; r_wwn = wwn;
    @(negedge clk);
    chk(!done, {"R9 done one cycle ", req}, 64'(done), 64'd0);
  endtask

  task automatic expect_result(input string req, input int off);
    chk(r_off == 7'(off), {req, " offset"}, 64'(r_off), 64'(off));
    chk(r_found == (off != 0), {"R9 found ", req}, 64'(r_found), 64'(off != 0));
    chk(r_wwn == exp_wwn(off), {req, " name (R6/R7)"}, r_wwn, exp_wwn(off));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 128; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !found && !rd_en, "R1 flags after reset", {61'd0, done, found, rd_en}, 64'd0);
    chk(wwn == 64'd0 && wwn_offset == 7'd0, "R1 name after reset", wwn, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      load_img(IMG[v]);
      run_scan(vec_tag(v));
      expect_result(vec_tag(v), EXP_OFF[v]);
    end

    // R3 high length byte carries the tag past the buffer
    load_img(256'h8400018D_0B003C08_00112233_44556677_88780000_00000000_00000000_00000000);
    run_scan("R3 high length byte");
    expect_result("R3 high length byte", 0);

    // R2 end tag with nonzero length bits
    load_img(256'h7F8D0B00_3C080011_22334455_66778800_00000000_00000000_00000000_00000000);
    run_scan("R2 end tag 0x7F");
    expect_result("R2 end tag 0x7F", 0);

    // R8 name cut off by the buffer end
    for (int k = 0; k < 128; k++) mem[k] = 8'h00;
    mem[116] = 8'h8D; mem[117] = 8'h0B; mem[118] = 8'h00;
    mem[119] = 8'h3C; mem[120] = 8'h08; mem[121] = 8'h00;
    for (int k = 122; k < 128; k++) mem[k] = 8'hC0 + 8'(k - 122);
    run_scan("R8 truncated name");
    expect_result("R8 truncated name", 0);

    // R8 name ending on the last byte
    for (int k = 0; k < 128; k++) mem[k] = 8'h00;
    mem[114] = 8'h8D; mem[115] = 8'h0B; mem[116] = 8'h00;
    mem[117] = 8'h3C; mem[118] = 8'h08; mem[119] = 8'h00;
    for (int k = 120; k < 128; k++) mem[k] = 8'h50 + 8'(k);
    run_scan("R8 name at last byte");
    expect_result("R8 name at last byte", 120);

    // R9 start during a scan is ignored
    load_img(IMG[1]);
    repeat (2) @(negedge clk);
    done_cnt = 0;
    begin
      int n = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (8) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (done_cnt == 0 && n < 2000) begin @(negedge clk); n++; end
      r_found = found; r_off = wwn_offset; r_wwn = wwn;
      repeat (300) @(negedge clk);
    end
    chk(done_cnt == 1, "R9 mid-scan start ignored", 64'(done_cnt), 64'd1);
    expect_result("R9 mid-scan start", 18);

    // R10 read spacing seen at the ports
    chk(gap_err == 0, "R10 rd_en spacing", 64'(gap_err), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule